// File: doc/BRIEF.md
# Switch-Matrix Routing Feasibility Checker

This block judges whether a set of connection demands can pass through one crossing point of a programmable routing fabric. The demand is a vector of six counts, one per connection type: types 1 and 2 run straight across (left-right and top-bottom), while types 3 to 6 turn a corner, with type 6 joining the left side to the bottom side. The track count `w` per side is a runtime input, so one instance serves every size up to the count width.

Two verdicts are produced. The first says whether the vector fits an ideal module, in which every side carries at most `w` nets. The second says whether the vector fits a quasi-universal crossbar-style matrix. That matrix also limits the combined straight traffic plus the heavier pair of opposing bent flows, with one exempt vector. The block also reports whether the request vector is dominated by a second reference vector presented in the same beat. A router or an architecture-exploration engine uses it to prune demand sets before it tries to find paths.

Inputs use a valid/ready handshake and results carry an output valid. The pipeline has two register stages and stalls as a whole while a result waits to be taken.

Top module: `rrv_feas_check`

## Requirements
- R1: After reset `out_valid_o` is low and `in_ready_o` is high.
- R2: A vector accepted on a rising edge (`in_valid_i` and `in_ready_o` high) gives its results with `out_valid_o` high after exactly two rising edges, provided the pipeline is not stalled in between.
- R3: Count `n(k)` sits at `req_i[(k-1)*6 +: 6]`. `univ_ok_o` is high exactly when n1+n3+n6, n2+n3+n4, n1+n4+n5 and n2+n5+n6 are each at most `w` and no count exceeds `w`. The sums are computed at full width without overflow.
- R4: `matrix_ok_o` is high exactly when `univ_ok_o` is high and, in addition, n1+n2+max(n3+n5, n4+n6) is at most 2w-1 (or R5 applies).
- R5: The vector (w, w, 0, 0, 0, 0) always yields `matrix_ok_o` high.
- R6: If any count exceeds `w`, `range_err_o` is high and both `univ_ok_o` and `matrix_ok_o` are low.
- R7: `dominated_o` is high exactly when each count of `req_i` is at most the count in the same field of `ref_i`. `ref_i` uses the same packing as `req_i`.
- R8: `in_ready_o` is low exactly while `out_valid_o` is high and `out_ready_i` is low. During such a stall all outputs hold their values and no new vector is taken.
- R9: `matrix_ok_o` is never high while `univ_ok_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input vector valid |
| in_ready_o | output | 1 | Input can be accepted |
| width_i | input | 6 | Tracks per side, w >= 1 |
| req_i | input | 36 | Six demand counts, 6 bits each, type 1 in the low field |
| ref_i | input | 36 | Reference vector for the dominance test |
| out_valid_o | output | 1 | Results valid |
| out_ready_i | input | 1 | Consumer takes the results |
| univ_ok_o | output | 1 | Fits the per-side limits |
| matrix_ok_o | output | 1 | Routable on a quasi-universal matrix |
| range_err_o | output | 1 | A count exceeds w |
| dominated_o | output | 1 | req is componentwise at most ref |

## Verification
A range error and the coupling limit can both apply to the same vector. The bench provokes this with a vector whose first count exceeds `w` while its straight and bent sums also exceed 2w-1. Only the range error may be reported, and both feasibility flags must be low. A stall and a new input can also meet in the same cycle. The bench holds `out_ready_i` low while it offers a second vector, checks that the first result stays frozen and that `in_ready_o` stays low, and then checks that the second vector appears intact two edges after release.

// File: rtl/rrv_pkg.sv
package rrv_pkg;
  parameter int CNT_W = 6;
  parameter int NTYPE = 6;
  localparam int SUM_W = CNT_W + 2;
  localparam int VEC_W = NTYPE * CNT_W;
  localparam int NSIDE = 4;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [SUM_W-1:0] sum_t;

  typedef struct packed {
    sum_t [NSIDE-1:0] side;
    sum_t             couple;
    cnt_t             w;
    logic             rerr;
    logic             exc;
    logic             dom;
  } stage_t;
endpackage

// File: rtl/rrv_range_dom.sv
module rrv_range_dom
  import rrv_pkg::*;
(
  input  logic [VEC_W-1:0] req_i,
  input  logic [VEC_W-1:0] ref_i,
  input  cnt_t             w_i,
  output logic             rerr_o,
  output logic             dom_o
);
  logic [NTYPE-1:0] over;
  logic [NTYPE-1:0] le_ref;

  for (genvar k = 0; k < NTYPE; k++) begin : g_type
    assign over[k]   = req_i[k*CNT_W +: CNT_W] > w_i;
    assign le_ref[k] = req_i[k*CNT_W +: CNT_W] <= ref_i[k*CNT_W +: CNT_W];
  end

  assign rerr_o = |over;
  assign dom_o  = &le_ref;
endmodule

// File: rtl/rrv_sum_stage.sv
module rrv_sum_stage
  import rrv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             vld_i,
  input  logic [VEC_W-1:0] req_i,
  input  logic [VEC_W-1:0] ref_i,
  input  cnt_t             w_i,
  output logic             vld_o,
  output stage_t           st_o
);
  sum_t [NTYPE-1:0] n;
  sum_t   bend_a, bend_b;
  logic   rerr, dom;
  logic   rest_zero;
  stage_t st_d;

  for (genvar k = 0; k < NTYPE; k++) begin : g_ext
    assign n[k] = sum_t'(req_i[k*CNT_W +: CNT_W]);
  end

  rrv_range_dom i_range_dom (
    .req_i  (req_i),
    .ref_i  (ref_i),
    .w_i    (w_i),
    .rerr_o (rerr),
    .dom_o  (dom)
  );

  assign bend_a    = n[2] + n[4];
  assign bend_b    = n[3] + n[5];
  assign rest_zero = (n[2] == '0) && (n[3] == '0) && (n[4] == '0) && (n[5] == '0);

  always_comb begin
    st_d.side[0] = n[0] + n[2] + n[5];
    st_d.side[1] = n[1] + n[2] + n[3];
    st_d.side[2] = n[0] + n[3] + n[4];
    st_d.side[3] = n[1] + n[4] + n[5];
    st_d.couple  = n[0] + n[1] + ((bend_a > bend_b) ? bend_a : bend_b);
    st_d.w       = w_i;
    st_d.rerr    = rerr;
    st_d.exc     = (n[0] == sum_t'(w_i)) && (n[1] == sum_t'(w_i)) && rest_zero;
    st_d.dom     = dom;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      st_o  <= '0;
    end else if (en_i) begin
      vld_o <= vld_i;
      st_o  <= st_d;
    end
  end
endmodule

// File: rtl/rrv_judge_stage.sv
module rrv_judge_stage
  import rrv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   vld_i,
  input  stage_t st_i,
  output logic   vld_o,
  output logic   univ_ok_o,
  output logic   matrix_ok_o,
  output logic   range_err_o,
  output logic   dominated_o
);
  logic [NSIDE-1:0] side_ok;
  logic univ_d, couple_ok;
  sum_t two_w;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    assign side_ok[s] = st_i.side[s] <= sum_t'(st_i.w);
  end

  assign two_w     = sum_t'(st_i.w) << 1;
  // couple <= 2w-1 written without a subtraction
  assign couple_ok = (st_i.couple + sum_t'(1)) <= two_w;
  assign univ_d    = !st_i.rerr && (&side_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o       <= 1'b0;
      univ_ok_o   <= 1'b0;
      matrix_ok_o <= 1'b0;
      range_err_o <= 1'b0;
      dominated_o <= 1'b0;
    end else if (en_i) begin
      vld_o       <= vld_i;
      univ_ok_o   <= univ_d;
      matrix_ok_o <= univ_d && (couple_ok || st_i.exc);
      range_err_o <= st_i.rerr;
      dominated_o <= st_i.dom;
    end
  end

  p_matrix_sub_univ_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (!matrix_ok_o || univ_ok_o));

  p_range_kills_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && range_err_o) |-> (!univ_ok_o && !matrix_ok_o));

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !en_i) |=> (vld_o && $stable({univ_ok_o, matrix_ok_o, range_err_o, dominated_o})));
endmodule

// File: rtl/rrv_feas_check.sv
module rrv_feas_check
  import rrv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [CNT_W-1:0] width_i,
  input  logic [VEC_W-1:0] req_i,
  input  logic [VEC_W-1:0] ref_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             univ_ok_o,
  output logic             matrix_ok_o,
  output logic             range_err_o,
  output logic             dominated_o
);
  logic   s1_vld;
  stage_t s1_st;
  logic   adv;

  // whole pipe moves unless a result is waiting
  assign adv        = !out_valid_o || out_ready_i;
  assign in_ready_o = adv;

  rrv_sum_stage i_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (adv),
    .vld_i  (in_valid_i),
    .req_i  (req_i),
    .ref_i  (ref_i),
    .w_i    (width_i),
    .vld_o  (s1_vld),
    .st_o   (s1_st)
  );

  rrv_judge_stage i_judge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (adv),
    .vld_i       (s1_vld),
    .st_i        (s1_st),
    .vld_o       (out_valid_o),
    .univ_ok_o   (univ_ok_o),
    .matrix_ok_o (matrix_ok_o),
    .range_err_o (range_err_o),
    .dominated_o (dominated_o)
  );

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) ##1 in_ready_o |=> out_valid_o);

  p_no_take_on_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o);
endmodule

// File: tb/test_rrv_feas_check.sv
`timescale 1ns/1ps
module test_rrv_feas_check;
  localparam int CW = 6;
  localparam int NT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, univ_ok, matrix_ok, range_err, dominated;
  logic [CW-1:0] width = '0;
  logic [NT*CW-1:0] req = '0, refv = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rrv_feas_check i_rrv_feas_check (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .width_i(width), .req_i(req), .ref_i(refv), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .univ_ok_o(univ_ok), .matrix_ok_o(matrix_ok),
    .range_err_o(range_err), .dominated_o(dominated)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  typedef int vec_t[6];

  function automatic logic [NT*CW-1:0] pack(vec_t v);
    logic [NT*CW-1:0] r = '0;
    for (int k = 0; k < 6; k++) r[k*CW +: CW] = CW'(v[k]);
    return r;
  endfunction

  // model from the requirements
  function automatic void model(vec_t n, vec_t m, int w,
                                output int eu, output int em, output int er, output int ed);
    int cp;
    er = 0; ed = 1;
    for (int k = 0; k < 6; k++) begin
      if (n[k] > w) er = 1;
      if (n[k] > m[k]) ed = 0;
    end
    eu = (!er && n[0]+n[2]+n[5] <= w && n[1]+n[2]+n[3] <= w &&
          n[0]+n[3]+n[4] <= w && n[1]+n[4]+n[5] <= w) ? 1 : 0;
    cp = n[0] + n[1] + ((n[2]+n[4] > n[3]+n[5]) ? n[2]+n[4] : n[3]+n[5]);
    em = (eu && (cp <= 2*w-1 ||
          (n[0]==w && n[1]==w && n[2]==0 && n[3]==0 && n[4]==0 && n[5]==0))) ? 1 : 0;
  endfunction

  task automatic run_vec(input string tag, input vec_t n, input vec_t m, input int w);
    int eu, em, er, ed;
    model(n, m, w, eu, em, er, ed);
    @(negedge clk);
    req = pack(n); refv = pack(m); width = CW'(w); in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R2 out_valid"}, out_valid, 1);
    chk({tag, " R3 univ_ok"}, univ_ok, eu);
    chk({tag, " R4 matrix_ok"}, matrix_ok, em);
    chk({tag, " R6 range_err"}, range_err, er);
    chk({tag, " R7 dominated"}, dominated, ed);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_directed();
    run_vec("R4 bent max", '{0,0,6,0,5,0}, '{6,6,6,6,6,6}, 6);
    run_vec("R4 coupling over", '{0,0,6,0,6,0}, '{0,0,6,0,6,0}, 6);
    run_vec("R5 exempt w6", '{6,6,0,0,0,0}, '{6,5,0,0,0,0}, 6);
    run_vec("R4 straight edge", '{5,6,0,0,0,0}, '{5,6,0,0,0,0}, 6);
    run_vec("R3 side over", '{3,3,3,3,0,0}, '{3,3,3,3,0,1}, 6);
    run_vec("R6 range", '{7,0,0,0,0,0}, '{7,0,0,0,0,0}, 6);
    run_vec("R6 range+coupling", '{7,6,6,0,6,0}, '{0,0,0,0,0,0}, 6);
    run_vec("R5 exempt w1", '{1,1,0,0,0,0}, '{1,1,0,0,0,0}, 1);
    run_vec("R4 w1 bent", '{0,0,1,0,1,0}, '{1,1,1,1,1,1}, 1);
    run_vec("R5 exempt w63", '{63,63,0,0,0,0}, '{63,63,0,0,0,0}, 63);
    run_vec("R3 wide sums", '{0,0,63,0,63,0}, '{63,63,63,63,63,63}, 63);
    run_vec("R7 one field", '{1,2,3,4,5,6}, '{1,2,3,4,4,6}, 63);
  endtask

  task automatic t_random();
    for (int i = 0; i < 60; i++) begin
      vec_t n, m;
      int w = 1 + int'($urandom_range(62));
      for (int k = 0; k < 6; k++) begin
        n[k] = int'($urandom_range(w));
        m[k] = int'($urandom_range(w));
      end
      if (i % 5 == 0) m = n;
      run_vec("R3 random", n, m, w);
    end
  endtask

  task automatic t_stall();
    int eu, em, er, ed;
    vec_t a = '{6,6,0,0,0,0};
    vec_t b = '{0,0,6,0,6,0};
    @(negedge clk);
    out_ready = 1'b0;
    req = pack(a); refv = pack(a); width = 6'd6; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R8 first result valid", out_valid, 1);
    chk("R8 ready low on stall", in_ready, 0);
    req = pack(b); refv = pack(a); in_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 held valid", out_valid, 1);
    chk("R8 held matrix_ok", matrix_ok, 1);
    chk("R8 held dominated", dominated, 1);
    chk("R8 ready still low", in_ready, 0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 drained", out_valid, 0);
    @(posedge clk);
    @(negedge clk);
    model(b, a, 6, eu, em, er, ed);
    chk("R8 second valid", out_valid, 1);
    chk("R8 second univ_ok", univ_ok, eu);
    chk("R8 second matrix_ok", matrix_ok, em);
    chk("R8 second dominated", dominated, ed);
  endtask

  task automatic t_back_to_back();
    vec_t a = '{0,0,3,0,2,0};
    vec_t b = '{0,0,3,0,3,0};
    @(negedge clk);
    width = 6'd3; req = pack(a); refv = pack(a); in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req = pack(b);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 first of pair valid", out_valid, 1);
    chk("R4 first of pair matrix_ok", matrix_ok, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R2 second of pair valid", out_valid, 1);
    chk("R9 second of pair matrix_ok", matrix_ok, 0);
    chk("R9 second of pair univ_ok", univ_ok, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_directed();
    t_back_to_back();
    t_stall();
    t_random();
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog got 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule